// File: doc/BRIEF.md
# Fault-Injection and Upstream-Gating Control Register

This block is a five-bit control register that diagnostic software uses to provoke bus faults on purpose and to pause outbound traffic on an I/O port. Software writes it and reads it through a simple CSR strobe interface. Its bits act over time rather than only holding a value. One bit gates the registered fatal-fault output. One bit freezes the upstream packet queue. One bit stops the data phase of broadcast writes. One bit inverts the status-check line for exactly one bus transaction. One bit spoils the parity of every CSR read.

The upstream side holds a small FIFO of command packets. While transmission is frozen, the FIFO fills and pushes back on its producer; nothing is lost. When the freeze is lifted, the stored packets leave in the order they arrived. The system bus, the transaction framing and the error logging are reduced to single-wire handshakes and strobes. Only the low five bits of the CSR write word are wired to the block.

Top module: `diag_inject_ctrl`

## Requirements
- R1: After reset every control field is 0. A read returns 0, `faultOut` is low, `pktOutValid` is low, `pktInReady` is high and `statChkOut` follows `statChkIn`.
- R2: `faultOut` is driven one clock after the cycle in which `fatalErrIn` was sampled. It is high only if `fatalErrIn` was high and field bit 4 (fault mask) was 0 in that cycle.
- R3: While field bit 3 (transmit hold) is 1, `pktOutValid` stays low. CSR reads still complete normally.
- R4: The upstream queue holds 4 packets. `queueFull` is high and `pktInReady` is low when it holds 4. A packet is accepted when valid and ready are both high, and it leaves when `pktOutValid` and `pktOutReady` are both high. No accepted packet is lost, and packets leave in the order they were accepted, including after the hold is released.
- R5: `bcastDataDrive` equals `bcastDataReq` while field bit 2 (data suppress) is 0, and is low while that bit is 1.
- R6: Writing 1 to field bit 1 arms a one-shot. The next `txnStart` consumes it. `statChkOut` is then the inverse of `statChkIn` from the `txnStart` cycle up to and including the `txnEnd` cycle, and equal to `statChkIn` at every other time. If start and end fall in the same cycle, only that cycle is inverted.
- R7: A write of field bit 1 that lands during a transaction, or in the same cycle as `txnStart`, arms the one-shot for the following transaction and not for the current one.
- R8: `csrRdEn` in one cycle gives `csrRdValid` high in the next cycle, with the field values as they stood in the cycle of the request. Bits 4, 3, 2 and 0 are returned at those bit positions. Bit 1 and bits 31:5 read as 0.
- R9: `csrRdParity` is the XOR of the 32 read-data bits (even parity). It is inverted if field bit 0 (parity force) was 1 in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| csrWrEn | input | 1 | CSR write strobe |
| csrWrData | input | 5 | Control field write value |
| csrRdEn | input | 1 | CSR read strobe |
| csrRdValid | output | 1 | Read data valid, one cycle after csrRdEn |
| csrRdData | output | 32 | Read data word |
| csrRdParity | output | 1 | Even parity of csrRdData, optionally inverted |
| fatalErrIn | input | 1 | Internal fatal error condition |
| faultOut | output | 1 | Registered, maskable fatal-fault output |
| pktInValid | input | 1 | Upstream packet offered |
| pktInReady | output | 1 | Queue can accept a packet |
| pktInData | input | 16 | Upstream packet payload |
| queueFull | output | 1 | Queue holds its full depth |
| pktOutValid | output | 1 | Packet available for transmission |
| pktOutReady | input | 1 | Bus accepts the packet |
| pktOutData | output | 16 | Head-of-queue packet |
| bcastDataReq | input | 1 | Broadcast write wants to drive its data |
| bcastDataDrive | output | 1 | Broadcast data actually driven |
| txnStart | input | 1 | Bus transaction start strobe |
| txnEnd | input | 1 | Bus transaction end strobe |
| statChkIn | input | 1 | Status-check value from the port logic |
| statChkOut | output | 1 | Status-check value sent to the bus |

## Verification
On every cycle the assertions check these properties: the fault mask blocks the fault, the transmit hold keeps valid low, the data suppress gates the broadcast drive, a full queue cannot leave the full state without a pop, inversion of the status-check line can only begin on a start strobe, and the unused read-data bits are zero. The timing of the one-shot across transaction boundaries cannot be seen at the ports from one cycle alone, and neither can the survival and ordering of packets across a hold and release. The bench's reference model shows those by tracking the armed state, the open transaction and the queue contents, and it compares all outputs on each clock in directed and random traffic.

// File: rtl/diag_pkg.sv
package diag_pkg;
  // field positions inside the control word
  localparam int FLD_FAULTMASK = 4;
  localparam int FLD_TXHOLD    = 3;
  localparam int FLD_DATASUP   = 2;
  localparam int FLD_FLIP      = 1;
  localparam int FLD_PARFRC    = 0;
  localparam int FLD_CNT       = 5;

  typedef struct packed {
    logic faultMask;
    logic txHold;
    logic dataSuppress;
    logic flipNow;
    logic parityForce;
  } ctlStrb_t;
endpackage

// File: rtl/diag_ctl.sv
module diag_ctl
  import diag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrWrEn,
  input  logic [FLD_CNT-1:0] wrField,
  input  logic               txnStart,
  input  logic               txnEnd,
  output ctlStrb_t           strb
);
  logic faultMaskQ, txHoldQ, dataSupQ, parForceQ;
  logic armedQ, activeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultMaskQ <= 1'b0;
      txHoldQ    <= 1'b0;
      dataSupQ   <= 1'b0;
      parForceQ  <= 1'b0;
    end else if (csrWrEn) begin
      faultMaskQ <= wrField[FLD_FAULTMASK];
      txHoldQ    <= wrField[FLD_TXHOLD];
      dataSupQ   <= wrField[FLD_DATASUP];
      parForceQ  <= wrField[FLD_PARFRC];
    end
  end

  // one-shot: armed by a write, consumed by the next start strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ  <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      if (csrWrEn && wrField[FLD_FLIP]) armedQ <= 1'b1;
      else if (txnStart)                armedQ <= 1'b0;

      if (txnStart && armedQ) activeQ <= !txnEnd;
      else if (txnEnd)        activeQ <= 1'b0;
    end
  end

  always_comb begin
    strb.faultMask    = faultMaskQ;
    strb.txHold       = txHoldQ;
    strb.dataSuppress = dataSupQ;
    strb.parityForce  = parForceQ;
    strb.flipNow      = activeQ | (txnStart & armedQ);
  end
endmodule

// File: rtl/diag_dp.sv
module diag_dp
  import diag_pkg::*;
#(
  parameter int CSR_W = 32,
  parameter int PKT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic             csrRdEn,
  output logic             csrRdValid,
  output logic [CSR_W-1:0] csrRdData,
  output logic             csrRdParity,
  input  logic             fatalErrIn,
  output logic             faultOut,
  input  logic             pktInValid,
  output logic             pktInReady,
  input  logic [PKT_W-1:0] pktInData,
  output logic             queueFull,
  output logic             pktOutValid,
  input  logic             pktOutReady,
  output logic [PKT_W-1:0] pktOutData,
  input  logic             bcastDataReq,
  output logic             bcastDataDrive,
  input  logic             statChkIn,
  output logic             statChkOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PKT_W-1:0] slotQ [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic             pushFire, popFire;

  assign queueFull   = (cnt == FULL_CNT);
  assign pktInReady  = !queueFull;
  assign pktOutValid = (cnt != '0) && !strb.txHold;
  assign pktOutData  = slotQ[rdPtr];
  assign pushFire    = pktInValid && pktInReady;
  assign popFire     = pktOutValid && pktOutReady;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (pushFire && wrPtr == PTR_W'(i)) slotQ[i] <= pktInData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (pushFire) wrPtr <= bump(wrPtr);
      if (popFire)  rdPtr <= bump(rdPtr);
      case ({pushFire, popFire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // CSR read view and parity
  logic [CSR_W-1:0] rdWord;
  always_comb begin
    rdWord                = '0;
    rdWord[FLD_FAULTMASK] = strb.faultMask;
    rdWord[FLD_TXHOLD]    = strb.txHold;
    rdWord[FLD_DATASUP]   = strb.dataSuppress;
    rdWord[FLD_PARFRC]    = strb.parityForce;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrRdValid  <= 1'b0;
      csrRdData   <= '0;
      csrRdParity <= 1'b0;
      faultOut    <= 1'b0;
    end else begin
      csrRdValid <= csrRdEn;
      if (csrRdEn) begin
        csrRdData   <= rdWord;
        csrRdParity <= (^rdWord) ^ strb.parityForce;
      end
      faultOut <= fatalErrIn && !strb.faultMask;
    end
  end

  assign bcastDataDrive = bcastDataReq && !strb.dataSuppress;
  assign statChkOut     = statChkIn ^ strb.flipNow;
endmodule

// File: rtl/diag_inject_ctrl.sv
module diag_inject_ctrl
  import diag_pkg::*;
#(
  parameter int CSR_W = 32,
  parameter int PKT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrWrEn,
  input  logic [FLD_CNT-1:0] csrWrData,
  input  logic               csrRdEn,
  output logic               csrRdValid,
  output logic [CSR_W-1:0]   csrRdData,
  output logic               csrRdParity,
  input  logic               fatalErrIn,
  output logic               faultOut,
  input  logic               pktInValid,
  output logic               pktInReady,
  input  logic [PKT_W-1:0]   pktInData,
  output logic               queueFull,
  output logic               pktOutValid,
  input  logic               pktOutReady,
  output logic [PKT_W-1:0]   pktOutData,
  input  logic               bcastDataReq,
  output logic               bcastDataDrive,
  input  logic               txnStart,
  input  logic               txnEnd,
  input  logic               statChkIn,
  output logic               statChkOut
);
  ctlStrb_t ctl;

  diag_ctl u_ctl (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .wrField(csrWrData),
    .txnStart(txnStart), .txnEnd(txnEnd), .strb(ctl)
  );

  diag_dp #(.CSR_W(CSR_W), .PKT_W(PKT_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(ctl),
    .csrRdEn(csrRdEn), .csrRdValid(csrRdValid), .csrRdData(csrRdData),
    .csrRdParity(csrRdParity), .fatalErrIn(fatalErrIn), .faultOut(faultOut),
    .pktInValid(pktInValid), .pktInReady(pktInReady), .pktInData(pktInData),
    .queueFull(queueFull), .pktOutValid(pktOutValid), .pktOutReady(pktOutReady),
    .pktOutData(pktOutData), .bcastDataReq(bcastDataReq),
    .bcastDataDrive(bcastDataDrive), .statChkIn(statChkIn), .statChkOut(statChkOut)
  );
endmodule

// File: rtl/diag_inject_ctrl_chk.sv
module diag_inject_ctrl_chk #(
  parameter int CSR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             fatalErrIn,
  input logic             faultOut,
  input logic             holdMask,
  input logic             txHold,
  input logic             dataSup,
  input logic             pktOutValid,
  input logic             pktOutReady,
  input logic             queueFull,
  input logic             bcastDataDrive,
  input logic             txnStart,
  input logic             statChkIn,
  input logic             statChkOut,
  input logic             csrRdValid,
  input logic [CSR_W-1:0] csrRdData
);
  logic flipping;
  assign flipping = statChkOut ^ statChkIn;

  // R2
  fault_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fatalErrIn && holdMask) |=> !faultOut);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txHold |-> !pktOutValid);

  // R4
  full_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queueFull && !(pktOutValid && pktOutReady)) |=> queueFull);

  // R5
  data_sup_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataSup |-> !bcastDataDrive);

  // R6
  flip_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flipping) |-> txnStart);

  // R8
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrRdValid |-> (csrRdData[CSR_W-1:5] == '0 && !csrRdData[1]));
endmodule

bind diag_inject_ctrl diag_inject_ctrl_chk #(.CSR_W(CSR_W)) u_chk (
  .clk(clk), .rstN(rstN), .fatalErrIn(fatalErrIn), .faultOut(faultOut),
  .holdMask(ctl.faultMask), .txHold(ctl.txHold), .dataSup(ctl.dataSuppress),
  .pktOutValid(pktOutValid), .pktOutReady(pktOutReady), .queueFull(queueFull),
  .bcastDataDrive(bcastDataDrive), .txnStart(txnStart), .statChkIn(statChkIn),
  .statChkOut(statChkOut), .csrRdValid(csrRdValid), .csrRdData(csrRdData)
);

// File: tb/diag_inject_ctrl_tb.sv
module diag_inject_ctrl_tb;
  localparam int CSR_W = 32;
  localparam int PKT_W = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrWrEn = 0, csrRdEn = 0, fatalErrIn = 0, pktInValid = 0, pktOutReady = 1;
  logic bcastDataReq = 0, txnStart = 0, txnEnd = 0, statChkIn = 0;
  logic [4:0] csrWrData = '0;
  logic [PKT_W-1:0] pktInData = '0;
  logic csrRdValid, csrRdParity, faultOut, pktInReady, queueFull, pktOutValid;
  logic bcastDataDrive, statChkOut;
  logic [CSR_W-1:0] csrRdData;
  logic [PKT_W-1:0] pktOutData;

  always #10 clk = ~clk;  // 50 MHz

  diag_inject_ctrl #(.CSR_W(CSR_W), .PKT_W(PKT_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdEn(csrRdEn), .csrRdValid(csrRdValid), .csrRdData(csrRdData),
    .csrRdParity(csrRdParity), .fatalErrIn(fatalErrIn), .faultOut(faultOut),
    .pktInValid(pktInValid), .pktInReady(pktInReady), .pktInData(pktInData),
    .queueFull(queueFull), .pktOutValid(pktOutValid), .pktOutReady(pktOutReady),
    .pktOutData(pktOutData), .bcastDataReq(bcastDataReq),
    .bcastDataDrive(bcastDataDrive), .txnStart(txnStart), .txnEnd(txnEnd),
    .statChkIn(statChkIn), .statChkOut(statChkOut)
  );

  int total = 0, fails = 0;
  bit started = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  bit fMask, fHold, fSup, fPar, mArmed, mActive, mFault, mRdValid, mRdPar;
  logic [CSR_W-1:0] mRdData;
  logic [PKT_W-1:0] mQ[$];

  function automatic logic [CSR_W-1:0] viewWord();
    logic [CSR_W-1:0] w = '0;
    w[4] = fMask; w[3] = fHold; w[2] = fSup; w[0] = fPar;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      fMask = 0; fHold = 0; fSup = 0; fPar = 0; mArmed = 0; mActive = 0;
      mFault = 0; mRdValid = 0; mRdPar = 0; mRdData = '0; mQ.delete();
    end else begin
      bit doPop, doPush;
      doPop  = (mQ.size() > 0) && !fHold && pktOutReady;
      doPush = pktInValid && (mQ.size() < DEPTH);
      mRdValid = csrRdEn;
      if (csrRdEn) begin
        mRdData = viewWord();
        mRdPar  = (^mRdData) ^ fPar;
      end
      mFault = fatalErrIn && !fMask;
      if (doPop) void'(mQ.pop_front());
      if (doPush) mQ.push_back(pktInData);
      if (txnStart && mArmed) begin
        mArmed  = 0;
        mActive = !txnEnd;
      end else if (txnEnd) mActive = 0;
      if (txnStart) mArmed = 0;
      if (csrWrEn) begin
        fMask = csrWrData[4]; fHold = csrWrData[3]; fSup = csrWrData[2];
        fPar = csrWrData[0];
        if (csrWrData[1]) mArmed = 1;
      end
    end
  end

  // per-clock comparison, away from both edges
  always begin
    @(negedge clk);
    #2;
    if (rstN && started) begin
      bit expFlip;
      expFlip = mActive || (txnStart && mArmed);
      chk(faultOut == mFault, "R2", "faultOut", faultOut, mFault);
      chk(pktOutValid == ((mQ.size() > 0) && !fHold), "R3", "pktOutValid",
          pktOutValid, (mQ.size() > 0) && !fHold);
      chk(queueFull == (mQ.size() == DEPTH), "R4", "queueFull", queueFull,
          mQ.size() == DEPTH);
      chk(pktInReady == (mQ.size() < DEPTH), "R4", "pktInReady", pktInReady,
          mQ.size() < DEPTH);
      if (mQ.size() > 0)
        chk(pktOutData == mQ[0], "R4", "pktOutData order", pktOutData, mQ[0]);
      chk(bcastDataDrive == (bcastDataReq && !fSup), "R5", "bcastDataDrive",
          bcastDataDrive, bcastDataReq && !fSup);
      chk(statChkOut == (statChkIn ^ expFlip), "R6/R7", "statChkOut",
          statChkOut, statChkIn ^ expFlip);
      chk(csrRdValid == mRdValid, "R8", "csrRdValid", csrRdValid, mRdValid);
      if (mRdValid) begin
        chk(csrRdData == mRdData, "R8", "csrRdData", csrRdData, mRdData);
        chk(csrRdParity == mRdPar, "R9", "csrRdParity", csrRdParity, mRdPar);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic csrWrite(input logic [4:0] d);
    csrWrEn = 1; csrWrData = d; tick(); csrWrEn = 0;
  endtask

  task automatic csrRead();
    csrRdEn = 1; tick(); csrRdEn = 0; tick();
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    tick(3);
    rstN = 1;
    tick();
    // R1 reset state observed directly
    chk(faultOut == 0, "R1", "faultOut", faultOut, 0);
    chk(pktOutValid == 0, "R1", "pktOutValid", pktOutValid, 0);
    chk(pktInReady == 1, "R1", "pktInReady", pktInReady, 1);
    chk(statChkOut == statChkIn, "R1", "statChkOut", statChkOut, statChkIn);
    started = 1;
    csrRdEn = 1; tick(); csrRdEn = 0;
    chk(csrRdData == '0 && csrRdValid, "R1", "readback", csrRdData, 0);
    tick();

    // R8/R9: all fields, parity forced
    csrWrite(5'h1F); csrRead();
    csrWrite(5'h01); csrRead();
    csrWrite(5'h0C); csrRead();

    // R2: fault masked, then unmasked
    csrWrite(5'h10);
    fatalErrIn = 1; tick(3);
    csrWrite(5'h00); tick(2);
    fatalErrIn = 0; tick(2);

    // R3/R4: hold, overfill, read during hold, release with backpressure
    csrWrite(5'h08);
    for (int i = 0; i < 6; i++) begin
      pktInValid = 1; pktInData = PKT_W'(16'hA0 + i); tick();
    end
    pktInValid = 0;
    csrRead();
    csrWrite(5'h00);
    for (int i = 0; i < 8; i++) begin
      pktOutReady = i[0]; tick();
    end
    pktOutReady = 1; tick(2);

    // R5
    csrWrite(5'h04); bcastDataReq = 1; tick(2);
    csrWrite(5'h00); tick(2); bcastDataReq = 0;

    // R6: armed outside a transaction, multi-cycle transaction
    csrWrite(5'h02); tick(2);
    txnStart = 1; statChkIn = 1; tick(); txnStart = 0;
    statChkIn = 0; tick(2); txnEnd = 1; tick(); txnEnd = 0; tick();
    // second transaction not flipped
    txnStart = 1; tick(); txnStart = 0; txnEnd = 1; tick(); txnEnd = 0; tick();
    // R7: write during a transaction arms the next one
    txnStart = 1; tick(); txnStart = 0; csrWrite(5'h02); tick();
    txnEnd = 1; tick(); txnEnd = 0; tick();
    txnStart = 1; txnEnd = 1; tick(); txnStart = 0; txnEnd = 0; tick();
    // R7: write in the start cycle of a transaction
    txnStart = 1; csrWrEn = 1; csrWrData = 5'h02; tick();
    txnStart = 0; csrWrEn = 0; txnEnd = 1; tick(); txnEnd = 0; tick();
    txnStart = 1; tick(); txnStart = 0; tick(); txnEnd = 1; tick(); txnEnd = 0;
    tick();

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      csrWrEn      = ($urandom_range(0, 9) == 0);
      csrWrData    = 5'($urandom);
      csrRdEn      = ($urandom_range(0, 5) == 0);
      fatalErrIn   = 1'($urandom);
      pktInValid   = 1'($urandom);
      pktInData    = PKT_W'($urandom);
      pktOutReady  = ($urandom_range(0, 3) != 0);
      bcastDataReq = 1'($urandom);
      txnStart     = ($urandom_range(0, 5) == 0);
      txnEnd       = ($urandom_range(0, 4) == 0);
      statChkIn    = 1'($urandom);
      tick();
    end
    csrWrEn = 0; csrRdEn = 0; pktInValid = 0; txnStart = 0; txnEnd = 0;
    tick(3);
    done = 1;
    finish();
  end
endmodule